// File: doc/BRIEF.md
# Two-Colour LED Matrix Row Scanner

This block refreshes a multiplexed LED matrix that has two colour planes (red and green) per pixel. The columns sit behind two external chains of serial-in, latched-output shift registers. The rows are chosen by an external 3-to-8 decoder. A fixed row period is counted in system clock cycles. In the last cycle of each period the scanner offers to take one row of data: one red word and one green word, each `COLS` bits wide. It takes the row through a valid/ready handshake.

The two words go out in lockstep on two serial data lines that share one shift clock. The shift clock's half-period is set by a divider parameter. After the last bit, one latch pulse common to both chains moves the data to the column drivers. The 3-bit row select then steps, and the active-low row enable is driven for a programmable number of cycles. A separate, slower active-low enable runs a global brightness PWM with its own programmable on-time. A pixel is lit only while both enables are low.

If no row was delivered in a period, the scanner shifts zeros and keeps the row enable inactive for that period. The row select still steps through all eight codes, so the frame length stays the same.

Top module: `lkd_scan_driver`

## Requirements
- R1: While `rst_n` is low: `sck_o`, `sd_red_o`, `sd_grn_o`, `latch_o` and `frame_start_o` are 0; `row_en_n_o` and `glb_en_n_o` are 1; `row_sel_o` is 7; `row_ready_o` is 1.
- R2: The period is `PERIOD` cycles. Phase p is the p-th cycle after the edge that ends a period. `row_ready_o` is high only in phase `PERIOD-1`. A row is taken at the edge that ends that phase if `row_valid_i` is high there.
- R3: For bit slot k (k from 0 to `COLS-1`), `sck_o` is low in phases 2·HALF·k through 2·HALF·k+HALF-1. It is high for the next HALF phases. After the last slot it stays low.
- R4: In slot k, `sd_red_o` and `sd_grn_o` carry bit `COLS-1-k` of the red and green word taken for this period. They are stable for the whole slot. From phase 2·HALF·COLS onward they are 0.
- R5: `latch_o` is high for exactly `LATCH` phases, beginning at phase 2·HALF·COLS+1. `sck_o` is low throughout.
- R6: `row_select_o` increases by one modulo 8 at phase 2·HALF·COLS+1+LATCH, so it wraps from 7 to 0. `frame_start_o` is high for that one phase exactly when the new value is 0.
- R7: In a period that took a row, `row_en_n_o` is low from phase 2·HALF·COLS+LATCH+2 for `row_on_time_i` phases, cut short at the end of the period. It is therefore never low while the latch is high or in the phase where the select changes.
- R8: In a period that took no row, `row_en_n_o` stays 1 and both data lines stay 0.
- R9: `glb_en_n_o` repeats every `GLB_PERIOD` cycles. It is 0 for the first `glb_on_time_i` cycles of each repetition and 1 for the rest. An on-time of 0 keeps it at 1. An on-time of `GLB_PERIOD` or more keeps it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid_i | input | 1 | Row data offered |
| row_red_i | input | COLS | Red plane bits of the row |
| row_grn_i | input | COLS | Green plane bits of the row |
| row_ready_o | output | 1 | Scanner takes a row at the next edge |
| row_on_time_i | input | $clog2(PERIOD+1) | Row enable on-time in cycles |
| glb_on_time_i | input | $clog2(GLB_PERIOD+1) | Global enable on-time in cycles |
| sck_o | output | 1 | Shared shift clock |
| sd_red_o | output | 1 | Serial data, red chain |
| sd_grn_o | output | 1 | Serial data, green chain |
| latch_o | output | 1 | Shared latch pulse, active high |
| row_sel_o | output | 3 | Binary row select code |
| row_en_n_o | output | 1 | Row enable, active low |
| glb_en_n_o | output | 1 | Global brightness enable, active low |
| frame_start_o | output | 1 | One-cycle pulse when the select returns to 0 |

## Verification
Two things can fall in the same cycle. One is taking the next row and reloading the shifter at the period boundary. The other is the current row still being lit, which happens when the on-time is long enough to run to the last phase. The bench provokes this with an on-time larger than the remaining period while rows are offered continuously. It then judges two points: the enable must release exactly at the period end, and the new row's first bit must appear in phase 0. The select wrap and the frame-start pulse also coincide with the end of the latch on every eighth row, and they are compared phase by phase against a model of the schedule.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
    localparam int SEL_W = 3;
    typedef logic [SEL_W-1:0] row_sel_t;
    localparam row_sel_t SEL_LAST = '1;
endpackage

// File: rtl/lkd_shifter.sv
module lkd_shifter #(
    parameter int COLS = 80,
    parameter int HALF = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [COLS-1:0] red_i,
    input  logic [COLS-1:0] grn_i,
    output logic            sck_o,
    output logic            sdr_o,
    output logic            sdg_o
);
    localparam int HC_W = $clog2(HALF + 1);
    localparam int BC_W = $clog2(COLS + 1);

    typedef struct packed {
        logic            act;
        logic            lvl;
        logic [HC_W-1:0] hc;
        logic [BC_W-1:0] bc;
        logic [COLS-1:0] r;
        logic [COLS-1:0] g;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.act = 1'b1;
            sh_d.lvl = 1'b0;
            sh_d.hc  = '0;
            sh_d.bc  = '0;
            sh_d.r   = red_i;
            sh_d.g   = grn_i;
        end else if (sh_q.act) begin
            if (sh_q.hc == HC_W'(HALF - 1)) begin
                sh_d.hc  = '0;
                sh_d.lvl = !sh_q.lvl;
                if (sh_q.lvl) begin
                    sh_d.r  = {sh_q.r[COLS-2:0], 1'b0};
                    sh_d.g  = {sh_q.g[COLS-2:0], 1'b0};
                    sh_d.bc = sh_q.bc + 1'b1;
                    if (sh_q.bc == BC_W'(COLS - 1)) sh_d.act = 1'b0;
                end
            end else begin
                sh_d.hc = sh_q.hc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck_o = sh_q.lvl;
    assign sdr_o = sh_q.r[COLS-1];
    assign sdg_o = sh_q.g[COLS-1];

    // R4
    sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> ($stable(sdr_o) && $stable(sdg_o)));

    // R3
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.bc <= BC_W'(COLS));
endmodule

// File: rtl/lkd_glb_pwm.sv
module lkd_glb_pwm #(
    parameter int PERIOD = 616000,
    localparam int W = $clog2(PERIOD + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] on_i,
    output logic         en_n_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         en_n;
    } pwm_t;

    pwm_t pw_d, pw_q;

    always_comb begin
        pw_d      = pw_q;
        pw_d.cnt  = (pw_q.cnt == W'(PERIOD - 1)) ? '0 : pw_q.cnt + 1'b1;
        pw_d.en_n = !(pw_d.cnt < on_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_q.cnt  <= W'(PERIOD - 1);
            pw_q.en_n <= 1'b1;
        end else begin
            pw_q <= pw_d;
        end
    end

    assign en_n_o = pw_q.en_n;

    // R9
    glb_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(on_i) == '0) |-> en_n_o);
endmodule

// File: rtl/lkd_scan_driver.sv
module lkd_scan_driver
    import lkd_pkg::*;
#(
    parameter int COLS       = 80,
    parameter int HALF       = 30,
    parameter int LATCH      = 30,
    parameter int PERIOD     = 38400,
    parameter int GLB_PERIOD = 616000,
    localparam int CW = $clog2(PERIOD + 1),
    localparam int GW = $clog2(GLB_PERIOD + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_valid_i,
    input  logic [COLS-1:0] row_red_i,
    input  logic [COLS-1:0] row_grn_i,
    output logic            row_ready_o,
    input  logic [CW-1:0]   row_on_time_i,
    input  logic [GW-1:0]   glb_on_time_i,
    output logic            sck_o,
    output logic            sd_red_o,
    output logic            sd_grn_o,
    output logic            latch_o,
    output logic [SEL_W-1:0] row_sel_o,
    output logic            row_en_n_o,
    output logic            glb_en_n_o,
    output logic            frame_start_o
);
    localparam int SHIFT_END = 2 * HALF * COLS;
    localparam int LAT_ON    = SHIFT_END + 1;
    localparam int SEL_STEP  = LAT_ON + LATCH;
    localparam int LIT_ON    = SEL_STEP + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          have;
        logic          ready;
        logic          latch;
        row_sel_t      sel;
        logic          en_n;
        logic          fs;
    } scan_t;

    scan_t sc_d, sc_q;
    logic            xfer;
    logic            load;
    logic [COLS-1:0] red_ld, grn_ld;

    always_comb begin
        sc_d     = sc_q;
        sc_d.cnt = (sc_q.cnt == CW'(PERIOD - 1)) ? '0 : sc_q.cnt + 1'b1;
        xfer     = sc_q.ready && row_valid_i;
        load     = (sc_d.cnt == '0);
        red_ld   = xfer ? row_red_i : '0;
        grn_ld   = xfer ? row_grn_i : '0;
        if (load) sc_d.have = xfer;
        sc_d.ready = (sc_d.cnt == CW'(PERIOD - 1));
        sc_d.latch = (sc_d.cnt >= CW'(LAT_ON)) && (sc_d.cnt < CW'(SEL_STEP));
        sc_d.fs    = 1'b0;
        if (sc_d.cnt == CW'(SEL_STEP)) begin
            sc_d.sel = sc_q.sel + 1'b1;
            sc_d.fs  = (sc_q.sel == SEL_LAST);
        end
        sc_d.en_n = !(sc_d.have && (sc_d.cnt >= CW'(LIT_ON)) &&
                      ((sc_d.cnt - CW'(LIT_ON)) < row_on_time_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q.cnt   <= CW'(PERIOD - 1);
            sc_q.have  <= 1'b0;
            sc_q.ready <= 1'b1;
            sc_q.latch <= 1'b0;
            sc_q.sel   <= SEL_LAST;
            sc_q.en_n  <= 1'b1;
            sc_q.fs    <= 1'b0;
        end else begin
            sc_q <= sc_d;
        end
    end

    lkd_shifter #(.COLS(COLS), .HALF(HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .red_i  (red_ld),
        .grn_i  (grn_ld),
        .sck_o  (sck_o),
        .sdr_o  (sd_red_o),
        .sdg_o  (sd_grn_o)
    );

    lkd_glb_pwm #(.PERIOD(GLB_PERIOD)) u_glb (
        .clk    (clk),
        .rst_n  (rst_n),
        .on_i   (glb_on_time_i),
        .en_n_o (glb_en_n_o)
    );

    assign row_ready_o   = sc_q.ready;
    assign latch_o       = sc_q.latch;
    assign row_sel_o     = sc_q.sel;
    assign row_en_n_o    = sc_q.en_n;
    assign frame_start_o = sc_q.fs;

    // R7
    lit_vs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_en_n_o |-> !latch_o);

    // R7
    sel_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_sel_o) |-> row_en_n_o);

    // R6
    fs_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (row_sel_o == '0));

    // R8
    blank_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_q.have |-> row_en_n_o);

    // R5
    latch_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> !sck_o);

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_ready_o |=> !row_ready_o);
endmodule

// File: tb/lkd_scan_driver_tb.sv
module lkd_scan_driver_tb;
    localparam int COLS = 8;
    localparam int HALF = 2;
    localparam int LATCH = 3;
    localparam int PERIOD = 60;
    localparam int GLB_PERIOD = 50;
    localparam int CW = $clog2(PERIOD + 1);
    localparam int GW = $clog2(GLB_PERIOD + 1);
    localparam int SHIFT_END = 2 * HALF * COLS;
    localparam int LAT_ON = SHIFT_END + 1;
    localparam int SEL_STEP = LAT_ON + LATCH;
    localparam int LIT_ON = SEL_STEP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_valid_i = 1'b0;
    logic [COLS-1:0] row_red_i = '0;
    logic [COLS-1:0] row_grn_i = '0;
    logic row_ready_o;
    logic [CW-1:0] row_on_time_i = '0;
    logic [GW-1:0] glb_on_time_i = '0;
    logic sck_o, sd_red_o, sd_grn_o, latch_o, row_en_n_o, glb_en_n_o, frame_start_o;
    logic [2:0] row_sel_o;

    always #5 clk = !clk;

    lkd_scan_driver #(.COLS(COLS), .HALF(HALF), .LATCH(LATCH),
                      .PERIOD(PERIOD), .GLB_PERIOD(GLB_PERIOD)) u_dut (
        .clk(clk), .rst_n(rst_n), .row_valid_i(row_valid_i),
        .row_red_i(row_red_i), .row_grn_i(row_grn_i), .row_ready_o(row_ready_o),
        .row_on_time_i(row_on_time_i), .glb_on_time_i(glb_on_time_i),
        .sck_o(sck_o), .sd_red_o(sd_red_o), .sd_grn_o(sd_grn_o),
        .latch_o(latch_o), .row_sel_o(row_sel_o), .row_en_n_o(row_en_n_o),
        .glb_en_n_o(glb_en_n_o), .frame_start_o(frame_start_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int ph = PERIOD - 1;
    int gph = GLB_PERIOD - 1;
    int sel_m = 7;
    bit have_m = 1'b0;
    logic [COLS-1:0] red_m = '0, grn_m = '0;

    int valid_pct = 100;
    int data_mode = 0;

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (phase %0d)", req, what, act, exp, ph);
        end
    endtask

    function automatic int exp_sck(input int p);
        return (p < SHIFT_END && (p % (2 * HALF)) >= HALF) ? 1 : 0;
    endfunction

    function automatic int exp_sd(input int p, input logic [COLS-1:0] w);
        if (p >= SHIFT_END) return 0;
        return int'(w[COLS - 1 - p / (2 * HALF)]);
    endfunction

    function automatic int exp_en_n(input int p, input bit h, input int on);
        if (h && p >= LIT_ON && (p - LIT_ON) < on) return 0;
        return 1;
    endfunction

    task automatic step();
        int fs_exp;
        @(negedge clk);
        ph = (ph + 1) % PERIOD;
        gph = (gph + 1) % GLB_PERIOD;
        if (ph == 0) begin
            have_m = row_valid_i;
            red_m = row_valid_i ? row_red_i : '0;
            grn_m = row_valid_i ? row_grn_i : '0;
        end
        fs_exp = 0;
        if (ph == SEL_STEP) begin
            sel_m = (sel_m + 1) % 8;
            fs_exp = (sel_m == 0) ? 1 : 0;
        end
        cmp("R2", "ready", int'(row_ready_o), (ph == PERIOD - 1) ? 1 : 0);
        cmp("R3", "sck", int'(sck_o), exp_sck(ph));
        cmp("R4", "sd_red", int'(sd_red_o), exp_sd(ph, red_m));
        cmp("R4", "sd_grn", int'(sd_grn_o), exp_sd(ph, grn_m));
        cmp("R5", "latch", int'(latch_o), (ph >= LAT_ON && ph < SEL_STEP) ? 1 : 0);
        cmp("R6", "sel", int'(row_sel_o), sel_m);
        cmp("R6", "frame_start", int'(frame_start_o), fs_exp);
        if (have_m) cmp("R7", "row_en_n", int'(row_en_n_o), exp_en_n(ph, have_m, int'(row_on_time_i)));
        else        cmp("R8", "row_en_n blank", int'(row_en_n_o), 1);
        cmp("R9", "glb_en_n", int'(glb_en_n_o), (gph < int'(glb_on_time_i)) ? 0 : 1);
        row_valid_i = (($urandom() % 100) < valid_pct);
        if (data_mode == 1) begin
            row_red_i = '1;
            row_grn_i = '1;
        end else begin
            row_red_i = COLS'($urandom());
            row_grn_i = COLS'($urandom());
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "sck", int'(sck_o), 0);
        cmp("R1", "sd_red", int'(sd_red_o), 0);
        cmp("R1", "sd_grn", int'(sd_grn_o), 0);
        cmp("R1", "latch", int'(latch_o), 0);
        cmp("R1", "sel", int'(row_sel_o), 7);
        cmp("R1", "row_en_n", int'(row_en_n_o), 1);
        cmp("R1", "glb_en_n", int'(glb_en_n_o), 1);
        cmp("R1", "frame_start", int'(frame_start_o), 0);
        cmp("R1", "ready", int'(row_ready_o), 1);
        row_on_time_i = CW'(10);
        glb_on_time_i = GW'(25);
        data_mode = 1;
        row_valid_i = 1'b1;
        row_red_i = '1;
        row_grn_i = '1;
        rst_n = 1'b1;
        // all-ones rows, continuous delivery
        run(2 * PERIOD);
        // random data, continuous delivery (R3, R4, R6 wrap)
        data_mode = 0;
        run(8 * PERIOD);
        // R8: no row offered for a whole period
        valid_pct = 0;
        run(PERIOD);
        valid_pct = 100;
        // R7: zero on-time, then on-time past period end (lit across boundary)
        row_on_time_i = '0;
        run(PERIOD);
        row_on_time_i = CW'((1 << CW) - 1);
        run(2 * PERIOD);
        // R9: global enable always dark, then always lit
        glb_on_time_i = '0;
        run(2 * GLB_PERIOD);
        glb_on_time_i = GW'(GLB_PERIOD + 3);
        run(2 * GLB_PERIOD);
        glb_on_time_i = GW'(1);
        run(GLB_PERIOD);
        // random mix with changing on-times
        valid_pct = 70;
        for (int k = 0; k < 12; k++) begin
            row_on_time_i = CW'($urandom() % 30);
            glb_on_time_i = GW'($urandom() % (GLB_PERIOD + 4));
            run(PERIOD);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule